// File: doc/BRIEF.md
# Synchronous Burst SRAM with Selectable Read Pipeline

This block is a synthesizable behavioural model of a synchronous static RAM. Each word holds four 8-bit byte lanes, and the depth is set by a parameter. A small burst engine sits in front of the array. An external address is captured when either of two active-low address strobes is seen at a clock edge. After that, the two low address bits step through a four-beat burst in cycles where the active-low step input is low. A mode input selects the beat order: interleaved, where each beat is the start offset XOR the beat count, or linear, where it is the start offset plus the beat count modulo 4. The upper address bits never move during a burst, so a burst stays inside its aligned four-word block.

Writes are steered by three controls. A global write strobe writes the whole word. A byte-write strobe works together with four per-lane enables. When neither applies, the cycle is a read. A second mode input selects pipelined or flow-through operation, and this changes two things. In flow-through mode the write controls are registered at the address edge, and the data follows at the next edge. In pipelined mode the controls are taken at the same edge as the data. Flow-through reads show the current word in the same cycle. Pipelined reads pass it through an output register, so it appears one cycle later. The output is driven only while output enable is low.

Words move on fixed cycle timing, and there is no back-pressure. For that reason the data pins carry no valid/ready pair. Every pin is a plain control or data pin.

Top module: `sbs_sram`

## Requirements
- R1: At a clock edge where `cpu_stb_n` or `ctl_stb_n` is low, `addr_in` is loaded, and the beat count restarts at 0. The current address in the next cycle equals `addr_in`.
- R2: At an edge where `cpu_stb_n` is low, every write control sampled at that edge is ignored. This holds in both modes and also when `ctl_stb_n` is low at the same edge. That cycle then starts a read.
- R3: At an edge with both strobes high, the beat count advances by one if `step_n` is low. If `step_n` is high, the count holds.
- R4: With `order_xor` = 1, the low two bits of the current address are the start offset XOR the beat count.
- R5: With `order_xor` = 0, the low two bits are (start offset + beat count) mod 4.
- R6: Address bits above bit 1 change only when an address is loaded. A burst therefore wraps inside its aligned four-word block.
- R7: When `all_wr_n` is low and no `cpu_stb_n` applies, all four lanes are written, whatever `lane_wr_n` and `lane_en_n` are.
- R8: When `all_wr_n` is high and `lane_wr_n` is low, each low bit `lane_en_n[i]` writes bits 8i+7..8i of the word. Lanes whose enable is high keep their old contents.
- R9: When `all_wr_n` and `lane_wr_n` are both high, or when `lane_wr_n` is low but all of `lane_en_n` are high, no lane of the memory changes.
- R10: In pipelined mode (`pipe_mode` = 1), the write controls and `wr_data` sampled at one edge act together on the word that was current before that edge. In flow-through mode, the controls sampled at an edge act at the next edge, with the `wr_data` sampled there, on the word that edge made current.
- R11: In flow-through mode, `rd_data` shows the current word in the same cycle. In pipelined mode it shows that word in the following cycle.
- R12: While `out_en_n` is high, `rd_data` is zero and `rd_drive` is low. While `out_en_n` is low, `rd_drive` is high. During reset, the pipelined output register reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_in | input | ADDR_W | External word address |
| cpu_stb_n | input | 1 | Priority address strobe; forces a read start |
| ctl_stb_n | input | 1 | Second address strobe |
| step_n | input | 1 | Advance the burst beat when low |
| order_xor | input | 1 | 1 = interleaved order, 0 = linear order |
| pipe_mode | input | 1 | 1 = pipelined, 0 = flow-through |
| all_wr_n | input | 1 | Global write, all lanes |
| lane_wr_n | input | 1 | Byte-write strobe |
| lane_en_n | input | LANES | Per-lane write enables, active low |
| wr_data | input | LANES*LANE_W | Write data |
| out_en_n | input | 1 | Output enable, active low |
| rd_data | output | LANES*LANE_W | Read data, zero when not enabled |
| rd_drive | output | 1 | High while the output is driven |

## Verification
Bursts are run from every start offset, in three different blocks (including the last block of the array), under both orders and both read modes. Some of these bursts include a held beat. This separates an XOR order from an add order, flow-through timing from pipelined timing, and stepping from holding. All sixteen lane-enable patterns are written in both modes over known data and then read back. Each byte lane is therefore shown to be written only under its own enable. Separate sequences put write controls in the strobe cycle rather than the data cycle, and assert both strobes together. These show which edge takes the controls in each mode, and that the priority strobe blocks writes.

// File: rtl/sbs_pkg.sv
package sbs_pkg;
  localparam int BEAT_W = 2;

  function automatic logic [BEAT_W-1:0] beat_offset(
    input logic [BEAT_W-1:0] start,
    input logic [BEAT_W-1:0] count,
    input logic              interleave
  );
    return interleave ? (start ^ count) : (start + count);
  endfunction
endpackage

// File: rtl/sbs_burst_addr.sv
module sbs_burst_addr
  import sbs_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] ext_addr,
  input  logic              cpu_stb_n,
  input  logic              ctl_stb_n,
  input  logic              step_n,
  input  logic              order_xor,
  output logic [ADDR_W-1:0] cur_addr
);
  localparam int HI_W = ADDR_W - BEAT_W;

  logic [HI_W-1:0]   base_q;
  logic [BEAT_W-1:0] start_q;
  logic [BEAT_W-1:0] cnt_q;
  logic              load;

  assign load = !cpu_stb_n || !ctl_stb_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q  <= '0;
      start_q <= '0;
      cnt_q   <= '0;
    end else if (load) begin
      base_q  <= ext_addr[ADDR_W-1:BEAT_W];
      start_q <= ext_addr[BEAT_W-1:0];
      cnt_q   <= '0;
    end else if (!step_n) begin
      cnt_q <= cnt_q + 2'd1;
    end
  end

  assign cur_addr = {base_q, beat_offset(start_q, cnt_q, order_xor)};

  // R1
  load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> cur_addr == $past(ext_addr));

  // R3
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && step_n) |=> cnt_q == $past(cnt_q));

  // R6
  base_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> cur_addr[ADDR_W-1:BEAT_W] == $past(cur_addr[ADDR_W-1:BEAT_W]));
endmodule

// File: rtl/sbs_write_decode.sv
module sbs_write_decode #(
  parameter int LANES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             block,
  input  logic             all_wr_n,
  input  logic             lane_wr_n,
  input  logic [LANES-1:0] lane_en_n,
  output logic [LANES-1:0] mask
);
  always_comb begin
    if (block)           mask = '0;
    else if (!all_wr_n)  mask = '1;
    else if (!lane_wr_n) mask = ~lane_en_n;
    else                 mask = '0;
  end

  // R8
  lane_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!block && all_wr_n && !lane_wr_n) |->
      $countones(mask) == LANES - $countones(lane_en_n));

  // R9
  read_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (all_wr_n && (lane_wr_n || lane_en_n == '1)) |-> mask == '0);
endmodule

// File: rtl/sbs_store.sv
module sbs_store #(
  parameter int ADDR_W = 10,
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADDR_W-1:0]       cur_addr,
  input  logic [LANES-1:0]        wr_mask,
  input  logic [LANES*LANE_W-1:0] wr_data,
  input  logic                    pipe_mode,
  output logic [LANES*LANE_W-1:0] rd_word
);
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int WORD_W = LANES * LANE_W;

  logic [WORD_W-1:0] mem [DEPTH];
  logic [WORD_W-1:0] ft_word;
  logic [WORD_W-1:0] pipe_q;

  always_ff @(posedge clk) begin
    for (int l = 0; l < LANES; l++) begin
      if (wr_mask[l]) mem[cur_addr][l*LANE_W +: LANE_W] <= wr_data[l*LANE_W +: LANE_W];
    end
  end

  assign ft_word = mem[cur_addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '0;
    else        pipe_q <= ft_word;
  end

  assign rd_word = pipe_mode ? pipe_q : ft_word;

  for (genvar g = 0; g < LANES; g++) begin : g_lane_chk
    // R8
    lane_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_mask[g] |=> mem[$past(cur_addr)][g*LANE_W +: LANE_W]
                     == $past(wr_data[g*LANE_W +: LANE_W]));
  end
endmodule

// File: rtl/sbs_sram.sv
module sbs_sram #(
  parameter int ADDR_W = 10,
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADDR_W-1:0]       addr_in,
  input  logic                    cpu_stb_n,
  input  logic                    ctl_stb_n,
  input  logic                    step_n,
  input  logic                    order_xor,
  input  logic                    pipe_mode,
  input  logic                    all_wr_n,
  input  logic                    lane_wr_n,
  input  logic [LANES-1:0]        lane_en_n,
  input  logic [LANES*LANE_W-1:0] wr_data,
  input  logic                    out_en_n,
  output logic [LANES*LANE_W-1:0] rd_data,
  output logic                    rd_drive
);
  localparam int WORD_W = LANES * LANE_W;

  logic [ADDR_W-1:0] cur_addr;
  logic [LANES-1:0]  live_mask;
  logic [LANES-1:0]  mask_q;
  logic [LANES-1:0]  eff_mask;
  logic [WORD_W-1:0] rd_word;

  sbs_burst_addr #(.ADDR_W(ADDR_W)) u_addr (
    .clk       (clk),
    .rst_n     (rst_n),
    .ext_addr  (addr_in),
    .cpu_stb_n (cpu_stb_n),
    .ctl_stb_n (ctl_stb_n),
    .step_n    (step_n),
    .order_xor (order_xor),
    .cur_addr  (cur_addr)
  );

  sbs_write_decode #(.LANES(LANES)) u_dec (
    .clk       (clk),
    .rst_n     (rst_n),
    .block     (!cpu_stb_n),
    .all_wr_n  (all_wr_n),
    .lane_wr_n (lane_wr_n),
    .lane_en_n (lane_en_n),
    .mask      (live_mask)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= '0;
    else        mask_q <= live_mask;
  end

  assign eff_mask = pipe_mode ? live_mask : mask_q;

  sbs_store #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .cur_addr  (cur_addr),
    .wr_mask   (eff_mask),
    .wr_data   (wr_data),
    .pipe_mode (pipe_mode),
    .rd_word   (rd_word)
  );

  assign rd_data  = out_en_n ? '0 : rd_word;
  assign rd_drive = !out_en_n;

  // R2
  cpu_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_stb_n |-> live_mask == '0);

  // R2
  cpu_block_flow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_stb_n && !pipe_mode) |=> (pipe_mode || eff_mask == '0));

  // R12
  oe_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_en_n |-> (rd_data == '0 && !rd_drive));
endmodule

// File: tb/tb_sbs_sram.sv
`timescale 1ns/1ps
module tb_sbs_sram;
  localparam int AW = 6;
  localparam int NW = 1 << AW;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [AW-1:0] addr_in = '0;
  logic        cpu_stb_n = 1'b1, ctl_stb_n = 1'b1, step_n = 1'b1;
  logic        order_xor = 1'b0, pipe_mode = 1'b0;
  logic        all_wr_n = 1'b1, lane_wr_n = 1'b1;
  logic [3:0]  lane_en_n = 4'hF;
  logic [31:0] wr_data = '0;
  logic        out_en_n = 1'b1;
  logic [31:0] rd_data;
  logic        rd_drive;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [31:0] shadow [NW];

  always #2 clk = ~clk;

  sbs_sram #(.ADDR_W(AW), .LANES(4), .LANE_W(8)) dut (
    .clk(clk), .rst_n(rst_n), .addr_in(addr_in), .cpu_stb_n(cpu_stb_n),
    .ctl_stb_n(ctl_stb_n), .step_n(step_n), .order_xor(order_xor),
    .pipe_mode(pipe_mode), .all_wr_n(all_wr_n), .lane_wr_n(lane_wr_n),
    .lane_en_n(lane_en_n), .wr_data(wr_data), .out_en_n(out_en_n),
    .rd_data(rd_data), .rd_drive(rd_drive)
  );

  function automatic logic [31:0] pat(input int a);
    return 32'hA500_0000 ^ (a * 32'h0103_0507);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    cpu_stb_n = 1'b1; ctl_stb_n = 1'b1; step_n = 1'b1;
    all_wr_n = 1'b1; lane_wr_n = 1'b1; lane_en_n = 4'hF;
  endtask

  task automatic read1(input int a, input string req);
    @(negedge clk); idle(); pipe_mode = 1'b0; out_en_n = 1'b0;
    addr_in = AW'(a); cpu_stb_n = 1'b0;
    @(negedge clk); cpu_stb_n = 1'b1;
    chk(req, rd_data, shadow[a]);
  endtask

  // R4 R5 R6 R11 R3: one burst with optional held beat
  task automatic burst(input int a, input bit ord, input bit pipe, input bit pause);
    int cnts[5];
    int len = pause ? 5 : 4;
    int lat = pipe ? 1 : 0;
    int st  = a & 3;
    if (pause) begin cnts[0]=0; cnts[1]=1; cnts[2]=1; cnts[3]=2; cnts[4]=3; end
    else       begin cnts[0]=0; cnts[1]=1; cnts[2]=2; cnts[3]=3; cnts[4]=3; end
    @(negedge clk); idle(); order_xor = ord; pipe_mode = pipe; out_en_n = 1'b0;
    addr_in = AW'(a); cpu_stb_n = 1'b0;
    for (int c = 0; c < len + lat; c++) begin
      @(negedge clk);
      cpu_stb_n = 1'b1;
      step_n = (c < len - 1 && cnts[c+1] != cnts[c]) ? 1'b0 : 1'b1;
      if (c >= lat) begin
        int k = cnts[c-lat];
        int off = ord ? (st ^ k) : ((st + k) & 3);
        chk(ord ? (pipe ? "R4/R11 xor pipe" : "R4 xor flow")
                : (pipe ? "R5/R11 lin pipe" : "R5 lin flow"),
            rd_data, shadow[(a & ~3) | off]);
      end
    end
    step_n = 1'b1;
  endtask

  initial begin
    // R12 reset state
    pipe_mode = 1'b1; out_en_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R12 reset pipe reg", rd_data, 32'h0);
    chk("R12 drive on", {31'd0, rd_drive}, 32'd1);
    out_en_n = 1'b1;
    @(negedge clk);
    chk("R12 reset oe off", rd_data, 32'h0);
    rst_n = 1'b1;

    // R7 R10 fill, flow-through global writes
    for (int a = 0; a < NW; a++) begin
      @(negedge clk); idle(); pipe_mode = 1'b0;
      addr_in = AW'(a); ctl_stb_n = 1'b0; all_wr_n = 1'b0;
      lane_wr_n = 1'b1; lane_en_n = 4'hF;
      @(negedge clk); ctl_stb_n = 1'b1; all_wr_n = 1'b1; wr_data = pat(a);
      shadow[a] = pat(a);
    end
    for (int a = 0; a < NW; a += 7) read1(a, "R7 fill readback");
    read1(NW - 1, "R7 fill last");

    // R1 R3 R4 R5 R6 R11 burst sweep
    for (int b = 0; b < 3; b++)
      for (int s = 0; s < 4; s++)
        for (int o = 0; o < 2; o++)
          for (int p = 0; p < 2; p++)
            for (int h = 0; h < 2; h++)
              burst((b == 0 ? 0 : (b == 1 ? 20 : NW - 4)) + s, o[0], p[0], h[0]);

    // R8 R9 all lane patterns, both modes
    for (int m = 0; m < 2; m++) begin
      for (int p = 0; p < 16; p++) begin
        int a = (m == 0 ? 16 : 32) + p;
        logic [31:0] nd = 32'h5A3C_961E ^ (p * 32'h1111_1111);
        logic [31:0] lm;
        for (int l = 0; l < 4; l++) lm[l*8 +: 8] = p[l] ? 8'h00 : 8'hFF;
        if (m == 0) begin
          @(negedge clk); idle(); pipe_mode = 1'b0;
          addr_in = AW'(a); ctl_stb_n = 1'b0; lane_wr_n = 1'b0; lane_en_n = p[3:0];
          @(negedge clk); idle(); wr_data = nd;
        end else begin
          @(negedge clk); idle(); pipe_mode = 1'b1;
          addr_in = AW'(a); ctl_stb_n = 1'b0;
          @(negedge clk); idle(); lane_wr_n = 1'b0; lane_en_n = p[3:0]; wr_data = nd;
          @(negedge clk); idle();
        end
        shadow[a] = (shadow[a] & ~lm) | (nd & lm);
      end
    end
    for (int a = 16; a < 48; a++) read1(a, (a == 31 || a == 47) ? "R9 all lanes off" : "R8 lane write");

    // R9 byte-write strobe high with enables low
    @(negedge clk); idle(); pipe_mode = 1'b0;
    addr_in = AW'(48); ctl_stb_n = 1'b0; lane_en_n = 4'h0;
    @(negedge clk); idle(); lane_en_n = 4'h0; wr_data = 32'hDEAD_BEEF;
    @(negedge clk); idle();
    read1(48, "R9 strobe high");

    // R10 pipelined: controls in strobe cycle hit the previous word
    @(negedge clk); idle(); pipe_mode = 1'b1; addr_in = AW'(50); cpu_stb_n = 1'b0;
    @(negedge clk); idle(); addr_in = AW'(51); ctl_stb_n = 1'b0; all_wr_n = 1'b0;
    wr_data = 32'h1357_9BDF;
    @(negedge clk); idle();
    shadow[50] = 32'h1357_9BDF;
    read1(50, "R10 pipe prev word");
    read1(51, "R10 pipe new word");

    // R2 pipelined: priority strobe blocks write
    @(negedge clk); idle(); pipe_mode = 1'b1; addr_in = AW'(52); cpu_stb_n = 1'b0;
    @(negedge clk); idle(); addr_in = AW'(53); cpu_stb_n = 1'b0; all_wr_n = 1'b0;
    wr_data = 32'h2468_ACE0;
    @(negedge clk); idle();
    read1(52, "R2 pipe old word");
    read1(53, "R2 pipe new word");

    // R2 flow-through: priority strobe blocks write
    @(negedge clk); idle(); pipe_mode = 1'b0; addr_in = AW'(54); cpu_stb_n = 1'b0; all_wr_n = 1'b0;
    @(negedge clk); idle(); wr_data = 32'h0F0F_F0F0;
    @(negedge clk); idle();
    read1(54, "R2 flow");

    // R2 both strobes together
    @(negedge clk); idle(); pipe_mode = 1'b0; addr_in = AW'(55);
    cpu_stb_n = 1'b0; ctl_stb_n = 1'b0; all_wr_n = 1'b0;
    @(negedge clk); idle(); wr_data = 32'h7777_8888;
    chk("R2 both strobes read", rd_data, shadow[55]);
    @(negedge clk); idle();
    read1(55, "R2 both strobes");

    // R1 second strobe loads address for read
    @(negedge clk); idle(); pipe_mode = 1'b0; addr_in = AW'(9); ctl_stb_n = 1'b0;
    @(negedge clk); idle();
    chk("R1 ctl strobe load", rd_data, shadow[9]);

    // R12 output enable
    @(negedge clk); idle(); pipe_mode = 1'b0; out_en_n = 1'b1; addr_in = AW'(5); cpu_stb_n = 1'b0;
    @(negedge clk); idle();
    chk("R12 oe off data", rd_data, 32'h0);
    chk("R12 oe off drive", {31'd0, rd_drive}, 32'd0);
    out_en_n = 1'b0;
    #0.5;
    chk("R12 oe on data", rd_data, shadow[5]);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule